// File: doc/BRIEF.md
# Multi-Turn Vernier Sync Correction Unit

This unit sits in one stage of a chain of absolute position stages. Each stage reads a 5-bit Gray code from its own track set. The upstream stage turns 16 times faster than this one, and the most significant bit of the upstream stage has the same angular resolution as the least significant bit of this stage. This stage converts its code to binary and uses the lowest binary bit only as a phase reference, not as data. The upper four binary bits form the output word. The unit compares the phase reference with the upstream MSB and moves the word by +1, 0 or -1, so that the word advances exactly when the upstream MSB flips.

A serial clock, idle high, is sampled in the system clock domain. The track code is latched on the first falling edge that follows a long idle-high stretch. The correction keeps following the upstream MSB through the first low period and the first high period of the serial clock, because that MSB may still settle during this time. The word is frozen on the next falling edge. A strap input selects whether this stage's reference bit trails the upstream MSB (strap high) or leads it (strap low).

Top module: `multiturn_sync`

## Requirements
- R1: After reset, `wordOut` is 0 and `tracking` is 0.
- R2: A falling edge of `sclk` captures `trackCode` only if `sclk` was high for at least IDLE_LEN system clocks just before it. `wordOut` shows the result one clock later and `tracking` rises. A falling edge after a shorter high stretch changes neither output.
- R3: The captured Gray code is converted to binary (b4 = g4, bi = bi+1 XOR gi). The reference bit is b0. When no correction applies, `wordOut` = b[4:1].
- R4: With `phaseTrail` = 1, a reference bit of 1 and `predMsb` = 0, `wordOut` = b[4:1] + 1.
- R5: With `phaseTrail` = 0, a reference bit of 0 and `predMsb` = 1, `wordOut` = b[4:1] - 1.
- R6: The +1 and -1 corrections wrap modulo 16 (15+1 gives 0, 0-1 gives 15).
- R7: While `tracking` is 1, `wordOut` follows `predMsb` with one clock of latency. This holds through the first low period and the first high period of `sclk`.
- R8: The second falling edge of `sclk` after capture clears `tracking`. From then on, `wordOut` holds through changes of `predMsb`, `trackCode` and short `sclk` pulses until the next capture.
- R9: Changes of `trackCode` after capture do not affect `wordOut` during tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock level, idle high |
| trackCode | input | 5 | Gray code read from this stage's tracks |
| predMsb | input | 1 | MSB of the upstream, faster stage |
| phaseTrail | input | 1 | Phase strap: 1 = reference trails, 0 = reference leads |
| wordOut | output | 4 | Corrected 4-bit binary word |
| tracking | output | 1 | High during the correction window |

## Verification
Random Gray codes are paired with random upstream MSB values and strap settings, so that all four combinations of reference bit and MSB occur in both phase modes. This separates the increment, the decrement and the neutral paths. Directed codes whose binary value is all ones and all zeros separate correct modulo-16 wrap from saturation. Inside each frame the MSB is toggled in the low and in the high period, and toggled again after closure. Together with a short-idle falling edge, this separates a live window from a frozen word and a true capture from a spurious one.

// File: rtl/mts_pkg.sv
package mts_pkg;
  typedef struct packed {
    logic capture;
    logic track;
  } mts_strobe_t;

  typedef enum logic [1:0] {
    ST_REST = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } mts_state_t;
endpackage

// File: rtl/mts_ctrl.sv
module mts_ctrl
  import mts_pkg::*;
#(
  parameter int IDLE_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  output mts_strobe_t strobe,
  output logic        tracking
);
  localparam int CNT_W = $clog2(IDLE_LEN + 1);
  localparam logic [CNT_W-1:0] IDLE_MAX = CNT_W'(IDLE_LEN);

  mts_state_t state, stateNext;
  logic sclkQ;
  logic [CNT_W-1:0] idleCnt;
  logic fallEdge, riseEdge, idleOk;

  assign fallEdge = sclkQ & ~sclk;
  assign riseEdge = ~sclkQ & sclk;
  assign idleOk   = (idleCnt == IDLE_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b1;
      idleCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (!sclk) idleCnt <= '0;
      else if (!idleOk) idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_REST: if (fallEdge && idleOk) stateNext = ST_LOW;
      ST_LOW:  if (riseEdge) stateNext = ST_HIGH;
      ST_HIGH: if (fallEdge) stateNext = ST_REST;
      default: stateNext = ST_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_REST;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capture = (state == ST_REST) && fallEdge && idleOk;
    strobe.track   = strobe.capture || (state != ST_REST);
  end

  assign tracking = (state != ST_REST);
endmodule

// File: rtl/mts_dp.sv
module mts_dp
  import mts_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  mts_strobe_t         strobe,
  input  logic [CODE_W-1:0]   trackCode,
  input  logic                predMsb,
  input  logic                phaseTrail,
  output logic [CODE_W-2:0]   wordOut,
  output logic [CODE_W-1:0]   capCode
);
  localparam int WORD_W = CODE_W - 1;

  logic [CODE_W-1:0] capReg, codeSel, binCode;
  logic [WORD_W-1:0] baseWord, nextWord;
  logic refBit, incTrail, decLead;

  always_comb begin
    codeSel = strobe.capture ? trackCode : capReg;
    binCode[CODE_W-1] = codeSel[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      binCode[i] = binCode[i+1] ^ codeSel[i];
    end
  end

  assign refBit   = binCode[0];
  assign baseWord = binCode[CODE_W-1:1];
  assign incTrail = phaseTrail & refBit & ~predMsb;
  assign decLead  = ~phaseTrail & ~refBit & predMsb;

  always_comb begin
    if (incTrail)     nextWord = baseWord + WORD_W'(1);
    else if (decLead) nextWord = baseWord - WORD_W'(1);
    else              nextWord = baseWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg  <= '0;
      wordOut <= '0;
    end else begin
      if (strobe.capture) capReg <= trackCode;
      if (strobe.track)   wordOut <= nextWord;
    end
  end

  assign capCode = capReg;
endmodule

// File: rtl/multiturn_sync.sv
module multiturn_sync
  import mts_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int IDLE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic [CODE_W-1:0] trackCode,
  input  logic              predMsb,
  input  logic              phaseTrail,
  output logic [CODE_W-2:0] wordOut,
  output logic              tracking
);
  mts_strobe_t strobe;
  logic [CODE_W-1:0] capCode;

  mts_ctrl #(.IDLE_LEN(IDLE_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclk     (sclk),
    .strobe   (strobe),
    .tracking (tracking)
  );

  mts_dp #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .trackCode  (trackCode),
    .predMsb    (predMsb),
    .phaseTrail (phaseTrail),
    .wordOut    (wordOut),
    .capCode    (capCode)
  );
endmodule

// File: rtl/multiturn_sync_chk.sv
module multiturn_sync_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              tracking,
  input logic              predMsb,
  input logic              phaseTrail,
  input logic [CODE_W-2:0] wordOut,
  input logic [CODE_W-1:0] capCode
);
  localparam int WORD_W = CODE_W - 1;

  function automatic logic [CODE_W-1:0] toBin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b = '0;
    for (int i = 0; i < CODE_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  function automatic logic [WORD_W-1:0] upper(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b = toBin(g);
    return b[CODE_W-1:1];
  endfunction

  function automatic logic lowBit(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b = toBin(g);
    return b[0];
  endfunction

  AST_TRAIL_INC: assert property (@(posedge clk) disable iff (!rstN)
    tracking && phaseTrail && lowBit(capCode) && !predMsb
    |=> wordOut == WORD_W'(upper($past(capCode)) + WORD_W'(1))); // R4

  AST_LEAD_DEC: assert property (@(posedge clk) disable iff (!rstN)
    tracking && !phaseTrail && !lowBit(capCode) && predMsb
    |=> wordOut == WORD_W'(upper($past(capCode)) - WORD_W'(1))); // R5

  AST_NEUTRAL: assert property (@(posedge clk) disable iff (!rstN)
    tracking && !(phaseTrail && lowBit(capCode) && !predMsb)
             && !(!phaseTrail && !lowBit(capCode) && predMsb)
    |=> wordOut == upper($past(capCode))); // R3

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !tracking |=> (tracking || $stable(wordOut))); // R8

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    tracking |=> $stable(capCode)); // R9
endmodule

bind multiturn_sync multiturn_sync_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tracking   (tracking),
  .predMsb    (predMsb),
  .phaseTrail (phaseTrail),
  .wordOut    (wordOut),
  .capCode    (capCode)
);

// File: tb/sim_multiturn_sync.sv
module sim_multiturn_sync;
  localparam int IDLE = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1;
  logic [4:0] trackCode = '0;
  logic predMsb = 1'b0;
  logic phaseTrail = 1'b1;
  logic [3:0] wordOut;
  logic tracking;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  multiturn_sync #(.CODE_W(5), .IDLE_LEN(IDLE)) u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .trackCode(trackCode),
    .predMsb(predMsb), .phaseTrail(phaseTrail),
    .wordOut(wordOut), .tracking(tracking)
  );

  function automatic logic [4:0] g2b(input logic [4:0] g);
    logic [4:0] b;
    b[4] = g[4];
    b[3] = b[4] ^ g[3];
    b[2] = b[3] ^ g[2];
    b[1] = b[2] ^ g[1];
    b[0] = b[1] ^ g[0];
    return b;
  endfunction

  function automatic logic [3:0] expWord(input logic [4:0] g, input logic m, input logic tr);
    logic [4:0] b;
    b = g2b(g);
    if (tr && b[0] && !m) return b[4:1] + 4'd1;
    if (!tr && !b[0] && m) return b[4:1] - 4'd1;
    return b[4:1];
  endfunction

  function automatic string tagOf(input logic [4:0] g, input logic m, input logic tr);
    logic [4:0] b;
    b = g2b(g);
    if (tr && b[0] && !m) return "R4";
    if (!tr && !b[0] && m) return "R5";
    return "R3";
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic [4:0] g, input logic m, input logic tr, input string wrapTag);
    logic [3:0] held;
    trackCode = g; predMsb = m; phaseTrail = tr;
    sclk = 1'b1; tick(IDLE + 2);
    sclk = 1'b0; tick(1);
    chk("R2", {3'b0, tracking}, 4'd1);
    chk(wrapTag.len() > 0 ? wrapTag : tagOf(g, m, tr), wordOut, expWord(g, m, tr));
    predMsb = ~m; tick(1);
    chk("R7", wordOut, expWord(g, ~m, tr));
    trackCode = ~g; tick(1);
    chk("R9", wordOut, expWord(g, ~m, tr));
    sclk = 1'b1; predMsb = m; tick(1);
    chk("R7", wordOut, expWord(g, m, tr));
    sclk = 1'b0; tick(1);
    chk("R8", {3'b0, tracking}, 4'd0);
    held = expWord(g, m, tr);
    predMsb = ~m; tick(2);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; tick(1);
      sclk = 1'b0; trackCode = g ^ 5'(k + 1); tick(1);
    end
    chk("R8", wordOut, held);
    sclk = 1'b1;
  endtask

  initial begin
    tick(3);
    chk("R1", wordOut, 4'd0);
    chk("R1", {3'b0, tracking}, 4'd0);
    rstN = 1'b1;
    tick(2);
    // R6 wrap corners: binary 31 trails to 0, binary 0 leads to 15
    runFrame(5'b10000, 1'b0, 1'b1, "R6");
    runFrame(5'b00000, 1'b1, 1'b0, "R6");
    // R2: short idle-high stretch must not capture
    begin
      logic [3:0] prev;
      prev = wordOut;
      trackCode = 5'b01011; predMsb = 1'b1; phaseTrail = 1'b1;
      sclk = 1'b1; tick(3);
      sclk = 1'b0; tick(2);
      chk("R2", {3'b0, tracking}, 4'd0);
      chk("R2", wordOut, prev);
      sclk = 1'b1;
    end
    void'($urandom(32'd1234));
    for (int n = 0; n < 40; n++) begin
      runFrame(5'($urandom), 1'($urandom), 1'($urandom), "");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule